// File: doc/BRIEF.md
# Interrupt Status and Mask Controller

This block collects event pulses from a network controller core and turns them into one active-low interrupt line for the host. Four sources are tracked: transmit started, receive collision counter wrapped, user-requested interrupt and transmit complete. Each source has a sticky status flag, an individual mask and a shared global enable. The host acknowledges a cause by writing 1 to the flag's bit position. Because reads return the live values, software can write back the word it just read to clear every cause it saw.

The transmit-complete source is qualified before it reaches its flag. A suppress control drops successful frames so that only errors count. A last-frame mode takes precedence over the suppress control: in that mode, only frames whose descriptor carries a last-frame marker count, whatever the outcome. A user interrupt is requested by writing a command bit. The block answers by raising the user flag, and acknowledging that flag drops the command bit as well. A stop request clears all flags and the command bit while leaving masks and controls untouched. A synchronous soft reset returns everything to its reset state.

Register map (word addresses): 0 = status, 1 = mask, 2 = control; every other address is unmapped. Status and mask share one bit order: bit 0 transmit started, bit 1 collision counter wrapped, bit 2 user interrupt, bit 3 transmit complete. Control bits: bit 0 global enable, bit 1 suppress successful transmit, bit 2 last-frame mode, bit 3 user interrupt command, bit 4 stop (write-only).

Top module: `irq_status_ctrl`

## Requirements
- R1: After hard reset, status reads 0, mask reads 0xF, control reads 0 and irqN is 1.
- R2: A pulse on txStartEvt sets status bit 0, and a pulse on collWrapEvt sets status bit 1; both flags stay set until cleared.
- R3: A write to address 0 clears each status flag whose data bit is 1 and leaves each flag whose data bit is 0 unchanged.
- R4: When a set event and a write-1 clear hit the same flag in the same cycle, the flag ends up set.
- R5: irqN is 0 exactly one cycle after a state in which the global enable is 1 and some status flag has its mask bit 0; otherwise irqN is 1.
- R6: Writing control bit 4 as 1 clears every status flag and the user command bit, while masks and control bits 0 to 2 take their normal write values; bit 4 reads back as 0.
- R7: A soft reset pulse clears status and control and sets every mask bit to 1.
- R8: Writing control bit 3 as 1 sets that bit and status bit 2; writing 1 to status bit 2 clears both.
- R9: With control bits 1 and 2 at 0, every frame end (txEndEvt) sets status bit 3.
- R10: With control bit 1 at 1 and bit 2 at 0, a frame end sets status bit 3 only when txEndOk is 0.
- R11: With control bit 2 at 1, a frame end sets status bit 3 only when txEndLast is 1, regardless of txEndOk and of control bit 1.
- R12: Data bits above the defined fields are ignored on write and read as 0; unmapped addresses read 0 and ignore writes.
- R13: Read data appears on regRdData one cycle after regRdEn and shows the state from before any write in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low hard reset |
| softReset | input | 1 | Synchronous soft reset pulse |
| regRdEn | input | 1 | Register read strobe |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | ADDR_W | Register word address |
| regWrData | input | DATA_W | Write data |
| regRdData | output | DATA_W | Registered read data |
| txStartEvt | input | 1 | Core began sending a frame |
| collWrapEvt | input | 1 | Receive collision counter wrapped |
| txEndEvt | input | 1 | Frame transmission finished |
| txEndOk | input | 1 | Finished frame had no error |
| txEndLast | input | 1 | Descriptor last-frame marker of the finished frame |
| irqN | output | 1 | Active-low interrupt |

## Verification
The bench builds the block with ADDR_W = 3 and DATA_W = 16. With a 3-bit address, random accesses reach every unmapped address as well as the three registers. A 16-bit data path leaves eleven reserved bits above the control field, so random data regularly tries to write the reserved positions. Random traffic also mixes stop requests, soft resets and event pulses that collide with acknowledgements, which exercises the set-over-clear rule and the transmit-complete qualification modes many times.

// File: rtl/irq_status_pkg.sv
package irq_status_pkg;

  localparam int NUM_SRC = 4;

  // status / mask bit positions
  localparam int SRC_TX_START  = 0;
  localparam int SRC_COLL_WRAP = 1;
  localparam int SRC_USER      = 2;
  localparam int SRC_TX_DONE   = 3;

  // control bit positions
  localparam int CTL_ENABLE      = 0;
  localparam int CTL_TXOK_SUPPR  = 1;
  localparam int CTL_LAST_TX_EN  = 2;
  localparam int CTL_USER_CMD    = 3;
  localparam int CTL_STOP        = 4;
  localparam int CTL_STORED_BITS = 4;

  typedef enum logic [1:0] {
    SEL_STATUS  = 2'd0,
    SEL_MASK    = 2'd1,
    SEL_CONTROL = 2'd2,
    SEL_NONE    = 2'd3
  } regSel_e;

  typedef enum logic [1:0] {
    TXQ_ALL,
    TXQ_ERR_ONLY,
    TXQ_LAST_ONLY
  } txQual_e;

  typedef struct packed {
    logic [NUM_SRC-1:0] setEvt;
    logic [NUM_SRC-1:0] clrBits;
    logic               maskWr;
    logic               ctrlWr;
    logic               stopReq;
    logic               cmdSet;
    logic               cmdClr;
    logic               softClr;
    logic               rdEn;
    regSel_e            rdSel;
  } strobe_t;

endpackage

// File: rtl/irq_status_decode.sv
module irq_status_decode
  import irq_status_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16
) (
  input  logic              softReset,
  input  logic              regRdEn,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  input  logic              txStartEvt,
  input  logic              collWrapEvt,
  input  logic              txEndEvt,
  input  logic              txEndOk,
  input  logic              txEndLast,
  input  logic              txOkSuppress,
  input  logic              lastTxEnable,
  output strobe_t           strobes
);

  regSel_e addrSel;
  txQual_e txMode;
  logic    txDoneSet;
  logic    wrStatus;
  logic    wrCtrl;

  always_comb begin
    if (regAddr == ADDR_W'(0))      addrSel = SEL_STATUS;
    else if (regAddr == ADDR_W'(1)) addrSel = SEL_MASK;
    else if (regAddr == ADDR_W'(2)) addrSel = SEL_CONTROL;
    else                            addrSel = SEL_NONE;
  end

  // last-frame mode overrides the suppress control
  always_comb begin
    if (lastTxEnable)      txMode = TXQ_LAST_ONLY;
    else if (txOkSuppress) txMode = TXQ_ERR_ONLY;
    else                   txMode = TXQ_ALL;
  end

  always_comb begin
    unique case (txMode)
      TXQ_LAST_ONLY: txDoneSet = txEndEvt && txEndLast;
      TXQ_ERR_ONLY:  txDoneSet = txEndEvt && !txEndOk;
      default:       txDoneSet = txEndEvt;
    endcase
  end

  assign wrStatus = regWrEn && (addrSel == SEL_STATUS);
  assign wrCtrl   = regWrEn && (addrSel == SEL_CONTROL);

  always_comb begin
    strobes = '0;
    strobes.setEvt[SRC_TX_START]  = txStartEvt;
    strobes.setEvt[SRC_COLL_WRAP] = collWrapEvt;
    strobes.setEvt[SRC_USER]      = wrCtrl && regWrData[CTL_USER_CMD];
    strobes.setEvt[SRC_TX_DONE]   = txDoneSet;
    strobes.clrBits = wrStatus ? regWrData[NUM_SRC-1:0] : '0;
    strobes.maskWr  = regWrEn && (addrSel == SEL_MASK);
    strobes.ctrlWr  = wrCtrl;
    strobes.stopReq = wrCtrl && regWrData[CTL_STOP];
    strobes.cmdSet  = wrCtrl && regWrData[CTL_USER_CMD];
    strobes.cmdClr  = wrStatus && regWrData[SRC_USER];
    strobes.softClr = softReset;
    strobes.rdEn    = regRdEn;
    strobes.rdSel   = addrSel;
  end

endmodule

// File: rtl/irq_status_regs.sv
module irq_status_regs
  import irq_status_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            strobes,
  input  logic [DATA_W-1:0]  regWrData,
  output logic [DATA_W-1:0]  regRdData,
  output logic               irqN,
  output logic [NUM_SRC-1:0] statusQ,
  output logic [NUM_SRC-1:0] maskQ,
  output logic               enableQ,
  output logic               txOkSuppressQ,
  output logic               lastTxEnableQ,
  output logic               userCmdQ
);

  localparam int PAD_STAT = DATA_W - NUM_SRC;
  localparam int PAD_CTRL = DATA_W - CTL_STORED_BITS;

  logic flagClear;
  assign flagClear = strobes.softClr || strobes.stopReq;

  // one sticky flag and one mask bit per source; set beats clear
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                   statusQ[i] <= 1'b0;
      else if (flagClear)          statusQ[i] <= 1'b0;
      else if (strobes.setEvt[i])  statusQ[i] <= 1'b1;
      else if (strobes.clrBits[i]) statusQ[i] <= 1'b0;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                maskQ[i] <= 1'b1;
      else if (strobes.softClr) maskQ[i] <= 1'b1;
      else if (strobes.maskWr)  maskQ[i] <= regWrData[i];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enableQ       <= 1'b0;
      txOkSuppressQ <= 1'b0;
      lastTxEnableQ <= 1'b0;
    end else if (strobes.softClr) begin
      enableQ       <= 1'b0;
      txOkSuppressQ <= 1'b0;
      lastTxEnableQ <= 1'b0;
    end else if (strobes.ctrlWr) begin
      enableQ       <= regWrData[CTL_ENABLE];
      txOkSuppressQ <= regWrData[CTL_TXOK_SUPPR];
      lastTxEnableQ <= regWrData[CTL_LAST_TX_EN];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               userCmdQ <= 1'b0;
    else if (flagClear)      userCmdQ <= 1'b0;
    else if (strobes.cmdSet) userCmdQ <= 1'b1;
    else if (strobes.cmdClr) userCmdQ <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) irqN <= 1'b1;
    else       irqN <= !(enableQ && |(statusQ & ~maskQ));
  end

  logic [CTL_STORED_BITS-1:0] ctrlView;
  always_comb begin
    ctrlView = '0;
    ctrlView[CTL_ENABLE]     = enableQ;
    ctrlView[CTL_TXOK_SUPPR] = txOkSuppressQ;
    ctrlView[CTL_LAST_TX_EN] = lastTxEnableQ;
    ctrlView[CTL_USER_CMD]   = userCmdQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) regRdData <= '0;
    else if (strobes.rdEn) begin
      unique case (strobes.rdSel)
        SEL_STATUS:  regRdData <= {{PAD_STAT{1'b0}}, statusQ};
        SEL_MASK:    regRdData <= {{PAD_STAT{1'b0}}, maskQ};
        SEL_CONTROL: regRdData <= {{PAD_CTRL{1'b0}}, ctrlView};
        default:     regRdData <= '0;
      endcase
    end
  end

endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
  import irq_status_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              softReset,
  input  logic              regRdEn,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic              txStartEvt,
  input  logic              collWrapEvt,
  input  logic              txEndEvt,
  input  logic              txEndOk,
  input  logic              txEndLast,
  output logic              irqN
);

  strobe_t            strobes;
  logic [NUM_SRC-1:0] statusQ;
  logic [NUM_SRC-1:0] maskQ;
  logic               enableQ;
  logic               txOkSuppressQ;
  logic               lastTxEnableQ;
  logic               userCmdQ;

  irq_status_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_decode (
    .softReset    (softReset),
    .regRdEn      (regRdEn),
    .regWrEn      (regWrEn),
    .regAddr      (regAddr),
    .regWrData    (regWrData),
    .txStartEvt   (txStartEvt),
    .collWrapEvt  (collWrapEvt),
    .txEndEvt     (txEndEvt),
    .txEndOk      (txEndOk),
    .txEndLast    (txEndLast),
    .txOkSuppress (txOkSuppressQ),
    .lastTxEnable (lastTxEnableQ),
    .strobes      (strobes)
  );

  irq_status_regs #(.DATA_W(DATA_W)) u_regs (
    .clk           (clk),
    .rstN          (rstN),
    .strobes       (strobes),
    .regWrData     (regWrData),
    .regRdData     (regRdData),
    .irqN          (irqN),
    .statusQ       (statusQ),
    .maskQ         (maskQ),
    .enableQ       (enableQ),
    .txOkSuppressQ (txOkSuppressQ),
    .lastTxEnableQ (lastTxEnableQ),
    .userCmdQ      (userCmdQ)
  );

endmodule

// File: rtl/irq_status_chk.sv
module irq_status_chk #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              softReset,
  input logic              regRdEn,
  input logic              regWrEn,
  input logic [ADDR_W-1:0] regAddr,
  input logic [DATA_W-1:0] regWrData,
  input logic [DATA_W-1:0] regRdData,
  input logic              txStartEvt,
  input logic              txEndEvt,
  input logic              txEndOk,
  input logic              txEndLast,
  input logic              irqN,
  input logic [3:0]        statusQ,
  input logic [3:0]        maskQ,
  input logic              enableQ,
  input logic              txOkSuppressQ,
  input logic              lastTxEnableQ
);

  logic stopWr;
  logic statusWr;
  logic unmapped;
  assign stopWr   = regWrEn && (regAddr == ADDR_W'(2)) && regWrData[4];
  assign statusWr = regWrEn && (regAddr == ADDR_W'(0));
  assign unmapped = regAddr > ADDR_W'(2);

  assert_soft_clear_R7: assert property (@(posedge clk) disable iff (!rstN)
    softReset |=> (statusQ == 4'd0 && maskQ == 4'hF && !enableQ));

  assert_stop_keeps_mask_R6: assert property (@(posedge clk) disable iff (!rstN)
    (stopWr && !softReset) |=> (statusQ == 4'd0 && maskQ == $past(maskQ)));

  assert_set_wins_R4: assert property (@(posedge clk) disable iff (!rstN)
    (txStartEvt && !softReset && !stopWr) |=> statusQ[0]);

  assert_zero_write_keeps_R3: assert property (@(posedge clk) disable iff (!rstN)
    (statusWr && !softReset) |=>
      ((($past(statusQ) & ~$past(regWrData[3:0])) & ~statusQ) == 4'd0));

  assert_irq_low_R5: assert property (@(posedge clk) disable iff (!rstN)
    (enableQ && |(statusQ & ~maskQ)) |=> !irqN);

  assert_irq_high_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!enableQ || (statusQ & ~maskQ) == 4'd0) |=> irqN);

  assert_ok_suppressed_R10: assert property (@(posedge clk) disable iff (!rstN)
    (txOkSuppressQ && !lastTxEnableQ && txEndEvt && txEndOk && !statusQ[3])
      |=> !statusQ[3]);

  assert_last_only_R11: assert property (@(posedge clk) disable iff (!rstN)
    (lastTxEnableQ && txEndEvt && !txEndLast && !statusQ[3]) |=> !statusQ[3]);

  assert_unmapped_zero_R12: assert property (@(posedge clk) disable iff (!rstN)
    (regRdEn && unmapped) |=> (regRdData == '0));

endmodule

bind irq_status_ctrl irq_status_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk           (clk),
  .rstN          (rstN),
  .softReset     (softReset),
  .regRdEn       (regRdEn),
  .regWrEn       (regWrEn),
  .regAddr       (regAddr),
  .regWrData     (regWrData),
  .regRdData     (regRdData),
  .txStartEvt    (txStartEvt),
  .txEndEvt      (txEndEvt),
  .txEndOk       (txEndOk),
  .txEndLast     (txEndLast),
  .irqN          (irqN),
  .statusQ       (statusQ),
  .maskQ         (maskQ),
  .enableQ       (enableQ),
  .txOkSuppressQ (txOkSuppressQ),
  .lastTxEnableQ (lastTxEnableQ)
);

// File: tb/tb_irq_status_ctrl.sv
`timescale 1ns/1ps
module tb_irq_status_ctrl;

  localparam int AW = 3;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          softReset = 1'b0;
  logic          regRdEn = 1'b0;
  logic          regWrEn = 1'b0;
  logic [AW-1:0] regAddr = '0;
  logic [DW-1:0] regWrData = '0;
  logic          txStartEvt = 1'b0;
  logic          collWrapEvt = 1'b0;
  logic          txEndEvt = 1'b0;
  logic          txEndOk = 1'b0;
  logic          txEndLast = 1'b0;
  wire  [DW-1:0] regRdData;
  wire           irqN;

  int total = 0;
  int bad = 0;

  // reference model state
  logic [3:0] mSt = 4'h0;
  logic [3:0] mMask = 4'hF;
  logic mEn = 1'b0, mSup = 1'b0, mLte = 1'b0, mCmd = 1'b0;

  always #2 clk = ~clk;

  irq_status_ctrl #(.ADDR_W(AW), .DATA_W(DW)) dut (
    .clk(clk), .rstN(rstN), .softReset(softReset),
    .regRdEn(regRdEn), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData),
    .txStartEvt(txStartEvt), .collWrapEvt(collWrapEvt),
    .txEndEvt(txEndEvt), .txEndOk(txEndOk), .txEndLast(txEndLast),
    .irqN(irqN)
  );

  function automatic logic [DW-1:0] modelRead(logic [AW-1:0] a);
    case (a)
      3'd0:    return {12'h0, mSt};
      3'd1:    return {12'h0, mMask};
      3'd2:    return {12'h0, mCmd, mLte, mSup, mEn};
      default: return '0;
    endcase
  endfunction

  function automatic logic modelIrq();
    return mEn && |(mSt & ~mMask);
  endfunction

  function automatic void modelUpdate();
    logic wrS, wrM, wrC, stop, txSet;
    logic [3:0] setV, clrV;
    wrS = regWrEn && regAddr == 3'd0;
    wrM = regWrEn && regAddr == 3'd1;
    wrC = regWrEn && regAddr == 3'd2;
    stop = wrC && regWrData[4];
    if (mLte)      txSet = txEndEvt && txEndLast;
    else if (mSup) txSet = txEndEvt && !txEndOk;
    else           txSet = txEndEvt;
    setV = {txSet, wrC && regWrData[3], collWrapEvt, txStartEvt};
    clrV = wrS ? regWrData[3:0] : 4'h0;
    if (softReset) begin
      mSt = 4'h0; mMask = 4'hF; mEn = 0; mSup = 0; mLte = 0; mCmd = 0;
    end else begin
      if (stop) begin
        mSt = 4'h0; mCmd = 1'b0;
      end else begin
        mSt = (mSt & ~clrV) | setV;
        if (wrC && regWrData[3]) mCmd = 1'b1;
        else if (clrV[2])        mCmd = 1'b0;
      end
      if (wrM) mMask = regWrData[3:0];
      if (wrC) begin
        mEn = regWrData[0]; mSup = regWrData[1]; mLte = regWrData[2];
      end
    end
  endfunction

  task automatic check(input bit ok, input string tag,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cycle(input string tag);
    logic [DW-1:0] expRd;
    logic expIrq;
    bit didRd;
    expRd  = modelRead(regAddr);
    expIrq = modelIrq();
    didRd  = regRdEn;
    modelUpdate();
    @(posedge clk);
    @(negedge clk);
    check(irqN == !expIrq, "R5 irq level", {15'h0, irqN}, {15'h0, !expIrq});
    if (didRd)
      check(regRdData == expRd, {"R13 model read ", tag}, regRdData, expRd);
    regRdEn = 0; regWrEn = 0; softReset = 0;
    txStartEvt = 0; collWrapEvt = 0; txEndEvt = 0; txEndOk = 0; txEndLast = 0;
  endtask

  task automatic readExpect(input logic [AW-1:0] a, input logic [DW-1:0] exp,
                            input string tag);
    regRdEn = 1; regAddr = a;
    cycle(tag);
    check(regRdData == exp, tag, regRdData, exp);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    regWrEn = 1; regAddr = a; regWrData = d;
    cycle("write");
  endtask

  task automatic frameEnd(input bit ok, input bit last);
    txEndEvt = 1; txEndOk = ok; txEndLast = last;
    cycle("frame end");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset values
    check(irqN == 1'b1, "R1 irq idle", {15'h0, irqN}, 16'h1);
    readExpect(3'd0, 16'h0, "R1 status");
    readExpect(3'd1, 16'hF, "R1 mask");
    readExpect(3'd2, 16'h0, "R1 control");

    // R2 event capture
    txStartEvt = 1; collWrapEvt = 1; cycle("events");
    cycle("idle");
    readExpect(3'd0, 16'h3, "R2 sticky flags");

    // R3 write-one-to-clear
    wr(3'd0, 16'h0000);
    readExpect(3'd0, 16'h3, "R3 zero write");
    wr(3'd0, 16'h0001);
    readExpect(3'd0, 16'h2, "R3 one write");

    // R4 set beats clear
    txStartEvt = 1; regWrEn = 1; regAddr = 3'd0; regWrData = 16'h0001;
    cycle("collide");
    readExpect(3'd0, 16'h3, "R4 set wins");

    // R5 interrupt output and latency
    wr(3'd1, 16'hFFFE);
    wr(3'd2, 16'h0001);
    check(irqN == 1'b1, "R5 one cycle delay", {15'h0, irqN}, 16'h1);
    cycle("idle");
    check(irqN == 1'b0, "R5 asserted", {15'h0, irqN}, 16'h0);
    wr(3'd0, 16'h0001);
    check(irqN == 1'b0, "R5 still low at clear", {15'h0, irqN}, 16'h0);
    cycle("idle");
    check(irqN == 1'b1, "R5 released", {15'h0, irqN}, 16'h1);

    // R6 stop
    txStartEvt = 1; cycle("event");
    wr(3'd2, 16'h0011);
    readExpect(3'd0, 16'h0, "R6 status cleared");
    readExpect(3'd1, 16'hE, "R6 mask kept");
    readExpect(3'd2, 16'h1, "R6 control kept");

    // R8 user interrupt handshake
    wr(3'd2, 16'h0009);
    readExpect(3'd0, 16'h4, "R8 user flag");
    readExpect(3'd2, 16'h9, "R8 command bit");
    wr(3'd0, 16'h0004);
    readExpect(3'd0, 16'h0, "R8 flag cleared");
    readExpect(3'd2, 16'h1, "R8 command cleared");

    // R9 default transmit-complete
    frameEnd(1, 0);
    readExpect(3'd0, 16'h8, "R9 ok frame");
    wr(3'd0, 16'h0008);

    // R10 suppress successful frames
    wr(3'd2, 16'h0003);
    frameEnd(1, 1);
    readExpect(3'd0, 16'h0, "R10 ok dropped");
    frameEnd(0, 0);
    readExpect(3'd0, 16'h8, "R10 error kept");
    wr(3'd0, 16'h0008);

    // R11 last-frame mode
    wr(3'd2, 16'h0007);
    frameEnd(1, 0);
    frameEnd(0, 0);
    readExpect(3'd0, 16'h0, "R11 unmarked dropped");
    frameEnd(1, 1);
    readExpect(3'd0, 16'h8, "R11 marked ok frame");
    wr(3'd0, 16'h0008);

    // R12 reserved bits and unmapped space
    wr(3'd1, 16'hFFF0);
    readExpect(3'd1, 16'h0, "R12 reserved mask bits");
    wr(3'd2, 16'hFFE1);
    readExpect(3'd2, 16'h1, "R12 reserved control bits");
    wr(3'd5, 16'hFFFF);
    readExpect(3'd5, 16'h0, "R12 unmapped read");
    readExpect(3'd1, 16'h0, "R12 unmapped write ignored");

    // R13 read before write in the same cycle
    regWrEn = 1; regWrData = 16'h0005;
    readExpect(3'd1, 16'h0, "R13 old value");
    readExpect(3'd1, 16'h5, "R13 new value");

    // R7 soft reset
    txStartEvt = 1; cycle("event");
    softReset = 1; cycle("soft reset");
    readExpect(3'd0, 16'h0, "R7 status");
    readExpect(3'd1, 16'hF, "R7 mask");
    readExpect(3'd2, 16'h0, "R7 control");

    // random traffic against the model
    for (int n = 0; n < 4000; n++) begin
      regRdEn   = ($urandom % 2) == 0;
      regWrEn   = ($urandom % 3) == 0;
      regAddr   = AW'($urandom % 8);
      regWrData = DW'($urandom);
      if (regAddr == 3'd2) regWrData[4] = ($urandom % 8) == 0;
      if (regAddr == 3'd2 && ($urandom % 2) == 0) regWrData[0] = 1'b1;
      softReset   = ($urandom % 300) == 0;
      txStartEvt  = ($urandom % 6) == 0;
      collWrapEvt = ($urandom % 7) == 0;
      txEndEvt    = ($urandom % 5) == 0;
      txEndOk     = ($urandom % 2) == 0;
      txEndLast   = ($urandom % 2) == 0;
      cycle("random");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule